// File: doc/BRIEF.md
# Robbed-Bit Signaling Integrator

This block watches a T1 serial stream, one bit per valid cycle, with the frame number, the channel number and the bit position supplied alongside each bit. In the signaling frames it picks the least significant bit of every channel and collects these bits into a per-channel signaling word. At the end of each multiframe it decides which signaling word each channel presents. When integration is on, a new word must repeat for a selectable number of consecutive multiframes before it is accepted. This keeps single noise hits on the span from reaching the signaling.

The accepted words are written back into the signaling positions of the outgoing stream. They are also exposed as one flat register vector. Mode inputs select superframe (12 frames) or extended superframe (24 frames) operation and the integration depth, or bypass integration altogether. A freeze input holds all signaling state across a multiframe boundary. A further input drives every robbed bit on the output to one.

Top module: `rbs_integrator`

## Requirements
- R1: A signaling bit is the bit with `in_bitpos` = 7 in frames 6 and 12 (12-frame mode), or in frames 6, 12, 18 and 24 (24-frame mode, `esf_sel`=1). Frames are numbered from 1. Frame 6 gives word bit 0, frame 12 bit 1, frame 18 bit 2 and frame 24 bit 3. In 12-frame mode, word bits 2 and 3 are taken as 0.
- R2: A multiframe ends on the valid bit with `in_bitpos`=7, `in_chan`=NCH-1 and frame 12 (or frame 24 in 24-frame mode). `sig_flat[4c+k]` is word bit k of channel c. It changes only at the second rising edge after that last bit and never elsewhere.
- R3: Each channel keeps a candidate word and a saturating repeat count. At a multiframe end the count becomes 1 if the extracted word differs from the candidate, and otherwise increases by 1. With `integ_mode` 1, 2 or 3, the word is accepted once the count reaches `integ_mode`+1, that is 2, 3 or 4 identical multiframes.
- R4: A word that differs for fewer multiframes than the threshold leaves `sig_flat` unchanged and restarts the count.
- R5: With `integ_mode`=0 (bypass), the extracted word goes to `sig_flat` at every multiframe end.
- R6: With `freeze`=1 at a multiframe end, the accepted word, the candidate and the count keep their values.
- R7: `out_vld` and `out_bit` follow `in_vld` and `in_bit` one cycle later. Bits outside signaling positions pass through unchanged, and `out_bit` is 0 when the input is not valid.
- R8: At a signaling position, `out_bit` carries the channel's accepted word bit. When `ones_ins`=1 it is 1 instead.
- R9: After reset, `sig_flat`, `out_vld` and `out_bit` are 0 and every candidate and count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Input bit valid |
| in_bit | input | 1 | Input data bit |
| in_frm | input | 5 | Frame number, 1 to 24 |
| in_chan | input | CHW (5) | Channel number, 0 to NCH-1 |
| in_bitpos | input | 3 | Bit position in channel, 7 = least significant |
| esf_sel | input | 1 | 1: 24-frame multiframe, 0: 12-frame |
| integ_mode | input | 2 | 0 bypass, 1..3 require 2..4 repeats |
| freeze | input | 1 | Hold signaling state at multiframe end |
| ones_ins | input | 1 | Force robbed bits to one on output |
| out_vld | output | 1 | Output bit valid |
| out_bit | output | 1 | Output data bit with signaling inserted |
| sig_flat | output | NCH*4 (96) | Accepted signaling words, 4 bits per channel |

## Verification
The bench injects one-multiframe hits on single channels. A design that skipped the count would accept the noise, and one that failed to restart the count would accept a word after non-consecutive repeats. It changes the threshold and the framing between multiframes and then checks the exact multiframe in which a word lands. An off-by-one threshold, or a 12-frame mode that left stale C and D bits, shows up as a wrong `sig_flat`. Freeze and bypass multiframes catch a design that advanced its counters while frozen. Every output bit is compared, so a robbed bit inserted at the wrong frame or channel, or inserted with stale state, is reported.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
    localparam int SIG_W = 4;
    localparam int FRM_W = 5;
    localparam int SIG_PERIOD = 6;
    localparam int LAST_FRM_SF = 12;
    localparam int LAST_FRM_ESF = 24;
    localparam int LSB_POS = 7;

    typedef logic [SIG_W-1:0] sig_t;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_REP2   = 2'd1,
        MODE_REP3   = 2'd2,
        MODE_REP4   = 2'd3
    } integ_mode_e;
endpackage

// File: rtl/rbs_pos_decode.sv
module rbs_pos_decode
    import rbs_pkg::*;
#(
    parameter int NCH = 24,
    parameter int CHW = $clog2(NCH)
) (
    input  logic             in_vld,
    input  logic [FRM_W-1:0] in_frm,
    input  logic [CHW-1:0]   in_chan,
    input  logic [2:0]       in_bitpos,
    input  logic             esf_sel,
    output logic             is_sig,
    output logic [1:0]       sig_idx,
    output logic             mf_end
);
    logic chan_ok;
    logic lsb;
    logic [FRM_W-1:0] last_frm;

    always_comb begin
        chan_ok  = {1'b0, in_chan} < (CHW+1)'(NCH);
        lsb      = in_vld && chan_ok && (in_bitpos == 3'(LSB_POS));
        last_frm = esf_sel ? FRM_W'(LAST_FRM_ESF) : FRM_W'(LAST_FRM_SF);
        is_sig   = 1'b0;
        sig_idx  = 2'd0;
        // frames 6, 12, 18, 24 map to word bits 0..3
        for (int k = 0; k < SIG_W; k++) begin
            if (in_frm == FRM_W'(SIG_PERIOD * (k + 1)) && (esf_sel || k < 2)) begin
                is_sig  = lsb;
                sig_idx = 2'(k);
            end
        end
        mf_end = lsb && (in_chan == CHW'(NCH - 1)) && (in_frm == last_frm);
    end
endmodule

// File: rtl/rbs_chan_integ.sv
module rbs_chan_integ
    import rbs_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_idx,
    input  logic       wr_bit,
    input  logic       mf_tick,
    input  logic       esf_sel,
    input  logic       freeze,
    input  logic [1:0] integ_mode,
    output sig_t       sig_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        sig_t             ext;
        sig_t             cand;
        logic [CNT_W-1:0] cnt;
        sig_t             sig;
    } ch_st_t;

    ch_st_t st_d, st_q;
    sig_t fresh;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] thr;

    always_comb begin
        st_d   = st_q;
        fresh  = esf_sel ? st_q.ext : {2'b00, st_q.ext[1:0]};
        thr    = CNT_W'(integ_mode) + CNT_W'(1);
        cnt_nx = (fresh != st_q.cand) ? CNT_W'(1)
               : ((st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + CNT_W'(1));
        if (wr_en) begin
            st_d.ext[wr_idx] = wr_bit;
        end
        if (mf_tick && !freeze) begin
            st_d.cand = fresh;
            st_d.cnt  = cnt_nx;
            if (integ_mode == MODE_BYPASS || cnt_nx >= thr) begin
                st_d.sig = fresh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_o = st_q.sig;

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_tick |=> $stable(sig_o)); // R2
    AST_ACCEPT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sig_o) && $past(integ_mode) != 2'd0) |-> (st_q.cnt > CNT_W'($past(integ_mode)))); // R3
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_tick && !freeze && integ_mode == 2'd0 && esf_sel) |=> (sig_o == $past(st_q.ext))); // R5
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_tick && freeze) |=> ($stable(sig_o) && $stable(st_q.cnt) && $stable(st_q.cand))); // R6
endmodule

// File: rtl/rbs_integrator.sv
module rbs_integrator
    import rbs_pkg::*;
#(
    parameter int NCH   = 24,
    parameter int CHW   = $clog2(NCH),
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic               in_bit,
    input  logic [FRM_W-1:0]   in_frm,
    input  logic [CHW-1:0]     in_chan,
    input  logic [2:0]         in_bitpos,
    input  logic               esf_sel,
    input  logic [1:0]         integ_mode,
    input  logic               freeze,
    input  logic               ones_ins,
    output logic               out_vld,
    output logic               out_bit,
    output logic [NCH*SIG_W-1:0] sig_flat
);
    typedef struct packed {
        logic out_vld;
        logic out_bit;
        logic mf_tick;
    } top_st_t;

    top_st_t st_d, st_q;
    logic is_sig;
    logic mf_end;
    logic [1:0] sig_idx;
    sig_t sig_arr [NCH];
    sig_t sel_sig;

    rbs_pos_decode #(.NCH(NCH), .CHW(CHW)) u_dec (
        .in_vld    (in_vld),
        .in_frm    (in_frm),
        .in_chan   (in_chan),
        .in_bitpos (in_bitpos),
        .esf_sel   (esf_sel),
        .is_sig    (is_sig),
        .sig_idx   (sig_idx),
        .mf_end    (mf_end)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            rbs_chan_integ #(.CNT_W(CNT_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (is_sig && (in_chan == CHW'(g))),
                .wr_idx     (sig_idx),
                .wr_bit     (in_bit),
                .mf_tick    (st_q.mf_tick),
                .esf_sel    (esf_sel),
                .freeze     (freeze),
                .integ_mode (integ_mode),
                .sig_o      (sig_arr[g])
            );
            assign sig_flat[g*SIG_W +: SIG_W] = sig_arr[g];
        end
    endgenerate

    always_comb begin
        sel_sig = '0;
        for (int i = 0; i < NCH; i++) begin
            if (in_chan == CHW'(i)) begin
                sel_sig = sig_arr[i];
            end
        end
        st_d.out_vld = in_vld;
        st_d.mf_tick = mf_end;
        if (!in_vld) begin
            st_d.out_bit = 1'b0;
        end else if (is_sig) begin
            st_d.out_bit = ones_ins ? 1'b1 : sel_sig[sig_idx];
        end else begin
            st_d.out_bit = in_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.out_vld;
    assign out_bit = st_q.out_bit;

    AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R7
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !out_bit)); // R7
    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !is_sig) |=> (out_bit == $past(in_bit))); // R7
    AST_ONES_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sig && ones_ins) |=> out_bit); // R8
endmodule

// File: tb/sim_rbs_integrator.sv
module sim_rbs_integrator;
    localparam int NCH = 24;
    localparam int CHW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic in_bit = 1'b0;
    logic [4:0] in_frm = 5'd1;
    logic [CHW-1:0] in_chan = '0;
    logic [2:0] in_bitpos = 3'd0;
    logic esf_sel = 1'b1;
    logic [1:0] integ_mode = 2'd1;
    logic freeze = 1'b0;
    logic ones_ins = 1'b0;
    logic out_vld;
    logic out_bit;
    logic [NCH*4-1:0] sig_flat;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string scen = "R9";

    logic [3:0] m_ext  [NCH];
    logic [3:0] m_cand [NCH];
    int         m_cnt  [NCH];
    logic [3:0] m_sig  [NCH];
    logic [3:0] tx_sig [NCH];
    logic [3:0] line   [NCH];

    always #10 clk = ~clk;

    rbs_integrator #(.NCH(NCH), .CHW(CHW), .CNT_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bit(in_bit),
        .in_frm(in_frm), .in_chan(in_chan), .in_bitpos(in_bitpos),
        .esf_sel(esf_sel), .integ_mode(integ_mode), .freeze(freeze),
        .ones_ins(ones_ins), .out_vld(out_vld), .out_bit(out_bit),
        .sig_flat(sig_flat)
    );

    task automatic chk(input logic [NCH*4-1:0] act, input logic [NCH*4-1:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*4-1:0] exp_flat();
        logic [NCH*4-1:0] v;
        for (int c = 0; c < NCH; c++) v[4*c +: 4] = m_sig[c];
        return v;
    endfunction

    function automatic void model_tick();
        logic [3:0] fresh;
        if (freeze) return;
        for (int c = 0; c < NCH; c++) begin
            fresh = esf_sel ? m_ext[c] : {2'b00, m_ext[c][1:0]};
            if (fresh != m_cand[c]) begin
                m_cand[c] = fresh;
                m_cnt[c] = 1;
            end else if (m_cnt[c] < 7) begin
                m_cnt[c]++;
            end
            if (integ_mode == 2'd0 || m_cnt[c] >= int'(integ_mode) + 1) m_sig[c] = fresh;
        end
    endfunction

    task automatic send_mf();
        int nf;
        logic bv, ev, is_s;
        nf = esf_sel ? 24 : 12;
        for (int f = 1; f <= nf; f++) begin
            for (int c = 0; c < NCH; c++) begin
                for (int b = 0; b < 8; b++) begin
                    is_s = (b == 7) && (f % 6 == 0);
                    if (is_s) begin
                        bv = tx_sig[c][f/6 - 1];
                        ev = ones_ins ? 1'b1 : m_sig[c][f/6 - 1];
                        m_ext[c][f/6 - 1] = bv;
                    end else begin
                        bv = 1'($urandom);
                        ev = bv;
                    end
                    @(negedge clk);
                    in_vld = 1'b1; in_bit = bv; in_frm = 5'(f);
                    in_chan = CHW'(c); in_bitpos = 3'(b);
                    @(posedge clk); #1;
                    if (is_s) chk({95'd0, out_bit}, {95'd0, ev}, ones_ins ? "R8 ones" : "R8 insert");
                    else chk({94'd0, out_vld, out_bit}, {94'd0, 1'b1, ev}, "R7 pass");
                    if (f == nf/2 && c == 0 && b == 0) chk(sig_flat, exp_flat(), "R2 mid-multiframe");
                end
            end
        end
        model_tick();
        @(negedge clk); in_vld = 1'b0;
        @(posedge clk); #1;
        chk({94'd0, out_vld, out_bit}, 96'd0, "R7 idle");
        @(negedge clk);
        @(posedge clk); #1;
        chk(sig_flat, exp_flat(), scen);
    endtask

    task automatic set_tx_line();
        for (int c = 0; c < NCH; c++) tx_sig[c] = line[c];
    endtask

    initial begin
        for (int w = 0; w < 190000; w++) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < NCH; c++) begin
            m_ext[c] = '0; m_cand[c] = '0; m_cnt[c] = 0; m_sig[c] = '0;
            line[c] = 4'($urandom);
        end
        repeat (3) @(posedge clk);
        #1;
        chk(sig_flat, 96'd0, "R9 reset sig");
        chk({94'd0, out_vld, out_bit}, 96'd0, "R9 reset out");
        @(negedge clk); rst_n = 1'b1;

        // two repeats needed (R3)
        esf_sel = 1'b1; integ_mode = 2'd1; set_tx_line();
        scen = "R3 first multiframe"; send_mf();
        scen = "R3 accept after 2"; send_mf();

        // single hit on channel 5 (R4)
        tx_sig[5] = ~line[5];
        scen = "R4 noise hit ignored"; send_mf();
        set_tx_line();
        scen = "R4 hit then restore"; send_mf();

        // depth 4 (R3)
        integ_mode = 2'd3;
        for (int c = 0; c < NCH; c++) line[c] = 4'($urandom);
        set_tx_line();
        for (int k = 0; k < 4; k++) begin
            scen = (k < 3) ? "R3 depth4 pending" : "R3 depth4 accept";
            send_mf();
        end

        // 12-frame bypass, C/D forced to zero (R1, R5)
        esf_sel = 1'b0; integ_mode = 2'd0;
        for (int c = 0; c < NCH; c++) line[c] = 4'($urandom);
        set_tx_line();
        scen = "R5 R1 bypass 12-frame"; send_mf();

        // freeze (R6)
        freeze = 1'b1;
        for (int c = 0; c < NCH; c++) line[c] = ~line[c];
        set_tx_line();
        scen = "R6 freeze hold"; send_mf();
        freeze = 1'b0;
        scen = "R5 after freeze"; send_mf();

        // ones insertion (R8)
        ones_ins = 1'b1; esf_sel = 1'b1;
        scen = "R8 ones multiframe"; send_mf();
        ones_ins = 1'b0;

        // random mix
        for (int r = 0; r < 8; r++) begin
            esf_sel = 1'($urandom);
            integ_mode = 2'($urandom);
            freeze = ($urandom % 5) == 0;
            ones_ins = ($urandom % 4) == 0;
            for (int c = 0; c < NCH; c++) begin
                if ($urandom % 3 == 0) line[c] = 4'($urandom);
                tx_sig[c] = ($urandom % 6 == 0) ? 4'($urandom) : line[c];
            end
            scen = "R2 R3 random";
            send_mf();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule